// File: doc/BRIEF.md
# Power-up reset time-out sequencer

This block keeps the processor core in reset after a power-on, a brown-out or a wake from sleep until the start-up delays have passed. Two delays can be chained. The first is a power-up timer that counts system-clock cycles. The second is an oscillator settle wait that counts rising edges of the oscillator clock. The oscillator mode code decides whether the settle wait is used, and an active-low enable decides whether the power-up timer is used.

The delays run from the release of the power-on pulse (or of the brown-out event). The external reset pin has no effect on them. The pin only gates the final internal reset. If the pin is held low past the end of the delays, releasing it lets the core run at once. A wake event reuses only the oscillator settle wait, and only in crystal modes.

Oscillator edges are brought into the system-clock domain through a synchronizer. The system clock must therefore run at more than twice the oscillator frequency.

Top module: `rt_timeout_seq`

## Requirements
- R1: While `por_pulse` is high, `core_rst` is 1 and `seq_done` is 0. The sequence starts at the first system-clock edge that sees `por_pulse` low, and that edge chooses the first stage.
- R2: With `pwrt_en_n` = 0 in a non-crystal mode, `seq_done` rises at the (PWRT_CYCLES+1)-th system-clock edge after release.
- R3: The crystal modes are codes 0, 1 and 2 on `osc_mode`. In these modes, once the power-up timer has expired (or at once when it is skipped), OST_CYCLES rising edges of `osc_clk` must be seen before `seq_done` rises. Codes 3 to 7 skip this wait.
- R4: `pwrt_en_n` = 1 skips the power-up timer. In a non-crystal mode (code 3 is the external-clock mode) with the timer skipped, `seq_done` rises at the first edge after release.
- R5: While `bor_evt` is high the sequence is held at its start. After `bor_evt` falls, the same delay chain as after a power-on runs, timed from the release.
- R6: A power-on or brown-out event during a time-out drops `seq_done` and restarts the whole chain from the beginning.
- R7: A one-cycle `wake_evt` in the done state of a crystal mode runs only the oscillator settle wait, never the power-up timer. In a non-crystal mode, `wake_evt` leaves `seq_done` high.
- R8: The chain runs whatever `ext_rst_n` does. `core_rst` equals NOT `ext_rst_n` OR NOT `seq_done`, so releasing the pin after done clears `core_rst` in the same cycle.
- R9: Once reached, `seq_done` stays high until a brown-out, a power-on or a crystal-mode wake event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| osc_clk | input | 1 | Oscillator clock whose rising edges are counted |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| bor_evt | input | 1 | Brown-out event, active high, sampled on clk_sys |
| wake_evt | input | 1 | Wake-from-sleep event, one-cycle pulse |
| ext_rst_n | input | 1 | External reset pin, active low |
| osc_mode | input | 3 | Oscillator mode code (0..2 crystal) |
| pwrt_en_n | input | 1 | Power-up timer enable, active low |
| core_rst | output | 1 | Internal reset to the core, active high |
| seq_done | output | 1 | Time-out chain complete |

## Verification
The bench times every combination of crystal or non-crystal mode, power-up timer on or off, and power-on or brown-out cause. A design that chains the stages in the wrong order, or that skips the wrong stage, misses the latency window. An off-by-one in the power-up counter shows up as an exact-count mismatch.

The bench also triggers a brown-out in the middle of each stage. A design that resumes instead of restarting finishes early.

It wakes the block in both classes of mode. A design that reruns the power-up timer on wake finishes outside the window, and one that reacts to wake in a non-crystal mode drops done.

Finally, it holds the external pin low across a whole sequence. A design that ties the timers to the pin never reports done while the pin is low, or does not release the core at once when the pin goes high.

// File: rtl/rt_pkg.sv
`timescale 1ns/1ps
package rt_pkg;
  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_PWRT = 2'd1,
    ST_OST  = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  localparam logic [2:0] MODE_LP  = 3'd0;
  localparam logic [2:0] MODE_XT  = 3'd1;
  localparam logic [2:0] MODE_HS  = 3'd2;
  localparam logic [2:0] MODE_EXT = 3'd3;
  localparam logic [2:0] MODE_RC  = 3'd4;
  localparam logic [2:0] MODE_INT = 3'd5;

  // crystal-type modes need the oscillator settle wait
  function automatic logic mode_is_crystal(input logic [2:0] m);
    return (m <= MODE_HS);
  endfunction

  // stage entered when the chain starts
  function automatic seq_state_t first_stage(input logic [2:0] m, input logic en_n);
    if (!en_n)               return ST_PWRT;
    else if (mode_is_crystal(m)) return ST_OST;
    else                     return ST_DONE;
  endfunction

  // stage entered when the power-up timer expires
  function automatic seq_state_t after_pwrt(input logic [2:0] m);
    return mode_is_crystal(m) ? ST_OST : ST_DONE;
  endfunction
endpackage

// File: rtl/rt_edge_sync.sv
`timescale 1ns/1ps
module rt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk or posedge arst) begin
        if (arst)        sh[g] <= 1'b0;
        else if (g == 0) sh[g] <= async_in;
        else             sh[g] <= sh[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/rt_ticker.sv
`timescale 1ns/1ps
module rt_ticker #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic arst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)     cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
  end

  assign last = (cnt == TOP);
endmodule

// File: rtl/rt_seq_fsm.sv
`timescale 1ns/1ps
module rt_seq_fsm
  import rt_pkg::*;
(
  input  logic       clk,
  input  logic       arst,
  input  logic       restart,
  input  logic       wake,
  input  logic [2:0] mode,
  input  logic       en_n,
  input  logic       pwrt_last,
  input  logic       osc_rise,
  input  logic       ost_last,
  output seq_state_t state,
  output logic       pwrt_run,
  output logic       ost_run,
  output logic       pwrt_expired,
  output logic       ost_expired
);
  seq_state_t nxt;

  assign pwrt_run     = (state == ST_PWRT);
  assign ost_run      = (state == ST_OST);
  assign pwrt_expired = pwrt_run & pwrt_last;
  assign ost_expired  = ost_run & osc_rise & ost_last;

  always_comb begin
    nxt = state;
    case (state)
      ST_ARM:  nxt = first_stage(mode, en_n);
      ST_PWRT: if (pwrt_expired) nxt = after_pwrt(mode);
      ST_OST:  if (ost_expired)  nxt = ST_DONE;
      ST_DONE: if (wake && mode_is_crystal(mode)) nxt = ST_OST;
      default: nxt = ST_ARM;
    endcase
    if (restart) nxt = ST_ARM;
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) state <= ST_ARM;
    else      state <= nxt;
  end
endmodule

// File: rtl/rt_timeout_seq.sv
`timescale 1ns/1ps
module rt_timeout_seq
  import rt_pkg::*;
#(
  parameter int PWRT_CYCLES = 4096,
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_sys,
  input  logic       osc_clk,
  input  logic       por_pulse,
  input  logic       bor_evt,
  input  logic       wake_evt,
  input  logic       ext_rst_n,
  input  logic [2:0] osc_mode,
  input  logic       pwrt_en_n,
  output logic       core_rst,
  output logic       seq_done
);
  seq_state_t fsm_state;
  logic osc_rise, pwrt_last, ost_last;
  logic pwrt_run, ost_run, pwrt_expired, ost_expired;

  rt_edge_sync #(.STAGES(SYNC_STAGES)) u_osc_sync (
    .clk(clk_sys), .arst(por_pulse), .async_in(osc_clk), .rise(osc_rise)
  );

  rt_ticker #(.LIMIT(PWRT_CYCLES)) u_pwrt (
    .clk(clk_sys), .arst(por_pulse), .clr(!pwrt_run),
    .inc(pwrt_run), .last(pwrt_last)
  );

  rt_ticker #(.LIMIT(OST_CYCLES)) u_ost (
    .clk(clk_sys), .arst(por_pulse), .clr(!ost_run),
    .inc(ost_run & osc_rise), .last(ost_last)
  );

  rt_seq_fsm u_fsm (
    .clk(clk_sys), .arst(por_pulse), .restart(bor_evt), .wake(wake_evt),
    .mode(osc_mode), .en_n(pwrt_en_n), .pwrt_last(pwrt_last),
    .osc_rise(osc_rise), .ost_last(ost_last), .state(fsm_state),
    .pwrt_run(pwrt_run), .ost_run(ost_run),
    .pwrt_expired(pwrt_expired), .ost_expired(ost_expired)
  );

  assign seq_done = (fsm_state == ST_DONE);
  assign core_rst = !ext_rst_n || !seq_done;
endmodule

// File: rtl/rt_timeout_chk.sv
`timescale 1ns/1ps
module rt_timeout_chk
  import rt_pkg::*;
(
  input logic       clk_sys,
  input logic       por_pulse,
  input logic       bor_evt,
  input logic       wake_evt,
  input logic       ext_rst_n,
  input logic [2:0] osc_mode,
  input logic       pwrt_en_n,
  input logic       core_rst,
  input logic       seq_done,
  input seq_state_t state,
  input logic       pwrt_expired,
  input logic       ost_expired
);
  a_r3_ost_only_crystal: assert property (@(posedge clk_sys) disable iff (por_pulse)
    (state == ST_OST) |-> mode_is_crystal(osc_mode));

  a_r4_pwrt_only_enabled: assert property (@(posedge clk_sys) disable iff (por_pulse)
    (state == ST_PWRT) |-> !pwrt_en_n);

  a_r6_bor_restarts: assert property (@(posedge clk_sys) disable iff (por_pulse)
    bor_evt |=> (state == ST_ARM) && !seq_done);

  a_r7_wake_skips_pwrt: assert property (@(posedge clk_sys) disable iff (por_pulse)
    (seq_done && wake_evt && !bor_evt) |=> (state != ST_PWRT));

  a_r1_order: assert property (@(posedge clk_sys) disable iff (por_pulse)
    (state == ST_OST && !bor_evt) |=> (state == ST_OST || state == ST_DONE));

  a_r9_done_holds: assert property (@(posedge clk_sys) disable iff (por_pulse)
    (seq_done && !bor_evt && !(wake_evt && mode_is_crystal(osc_mode))) |=> seq_done);

  a_r3_done_from_ost: assert property (@(posedge clk_sys) disable iff (por_pulse)
    ($rose(seq_done) && mode_is_crystal(osc_mode)) |-> $past(ost_expired));

  a_r8_pin_holds_core: assert property (@(posedge clk_sys) disable iff (por_pulse)
    (!ext_rst_n || (state != ST_DONE)) |-> core_rst);

  a_r2_pwrt_exit: assert property (@(posedge clk_sys) disable iff (por_pulse)
    (pwrt_expired && !bor_evt) |=> (state != ST_PWRT));
endmodule

bind rt_timeout_seq rt_timeout_chk u_chk (
  .clk_sys(clk_sys), .por_pulse(por_pulse), .bor_evt(bor_evt),
  .wake_evt(wake_evt), .ext_rst_n(ext_rst_n), .osc_mode(osc_mode),
  .pwrt_en_n(pwrt_en_n), .core_rst(core_rst), .seq_done(seq_done),
  .state(fsm_state), .pwrt_expired(pwrt_expired), .ost_expired(ost_expired)
);

// File: tb/test_rt_timeout_seq.sv
`timescale 1ns/1ps
module test_rt_timeout_seq;
  localparam int P   = 20;
  localparam int OST = 1024;
  localparam int OSC_SYS = 4;   // osc period in system clocks

  logic clk = 1'b0, osc = 1'b0;
  logic por = 1'b1, bor = 1'b0, wake = 1'b0, ext_n = 1'b1, en_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic core_rst, seq_done;
  int total = 0, bad = 0;
  int n;
  bit finished = 0;

  always #10 clk = ~clk;
  always #40 osc = ~osc;

  rt_timeout_seq #(.PWRT_CYCLES(P), .OST_CYCLES(OST)) i_rt_timeout_seq (
    .clk_sys(clk), .osc_clk(osc), .por_pulse(por), .bor_evt(bor),
    .wake_evt(wake), .ext_rst_n(ext_n), .osc_mode(mode), .pwrt_en_n(en_n),
    .core_rst(core_rst), .seq_done(seq_done)
  );

  // {cause(1=brown-out), mode, en_n, class: bit1 settle wait, bit0 power-up timer}
  localparam logic [6:0] VECS [11] = '{
    7'b0_000_0_11, 7'b1_001_1_10, 7'b1_010_0_11, 7'b0_010_1_10,
    7'b0_011_0_01, 7'b0_011_1_00, 7'b1_100_0_01, 7'b1_100_1_00,
    7'b0_101_0_01, 7'b0_101_1_00, 7'b1_111_1_00
  };

  task automatic chk_eq(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(string tag, int act, int lo, int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  function automatic int lat_lo(logic [1:0] cls, int base0);
    int b = base0 + (cls[0] ? P : 0);
    return cls[1] ? b + OSC_SYS * (OST - 1) + 1 : b;
  endfunction
  function automatic int lat_hi(logic [1:0] cls, int base0);
    int b = base0 + (cls[0] ? P : 0);
    return cls[1] ? b + OSC_SYS * (OST - 1) + 9 : b;
  endfunction

  // count edges until done is seen
  task automatic measure(output int cnt);
    cnt = 0;
    do begin
      @(posedge clk); #1; cnt++;
    end while (!seq_done && cnt < 6000);
  endtask

  task automatic fire(logic cause);
    @(negedge clk);
    if (cause) begin
      bor = 1'b1; @(negedge clk); @(negedge clk); bor = 1'b0;
    end else begin
      por = 1'b1; @(negedge clk); @(negedge clk); #1;
      chk_eq("R1 core_rst in por", int'(core_rst), 1);
      chk_eq("R1 done in por", int'(seq_done), 0);
      @(negedge clk); por = 1'b0;
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // vector walk: R2 R3 R4 R5
    for (int i = 0; i < 11; i++) begin
      mode = VECS[i][5:3]; en_n = VECS[i][2];
      fire(VECS[i][6]);
      measure(n);
      chk_rng($sformatf("R2/R3/R4/R5 vec %0d latency", i), n,
              lat_lo(VECS[i][1:0], 1), lat_hi(VECS[i][1:0], 1));
    end

    // R6: brown-out mid power-up timer, non-crystal
    mode = 3'd3; en_n = 1'b0;
    fire(1'b0);
    repeat (10) @(negedge clk);
    fire(1'b1);
    measure(n);
    chk_eq("R6 restart in pwrt", n, P + 1);

    // R6: power-on again mid settle wait, crystal, timer off
    mode = 3'd1; en_n = 1'b1;
    fire(1'b0);
    repeat (300) @(negedge clk);
    #1 chk_eq("R6 still waiting", int'(seq_done), 0);
    fire(1'b0);
    measure(n);
    chk_rng("R6 restart in ost", n, lat_lo(2'b10, 1), lat_hi(2'b10, 1));

    // R9: done holds
    repeat (50) @(negedge clk);
    #1 chk_eq("R9 done holds", int'(seq_done), 1);

    // R7: crystal wake, timer enabled but unused
    mode = 3'd2; en_n = 1'b0;
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0; #1;
    chk_eq("R7 done drops on wake", int'(seq_done), 0);
    measure(n);
    chk_rng("R7 wake latency", n, lat_lo(2'b10, 0), lat_hi(2'b10, 0));

    // R7: non-crystal wake ignored
    mode = 3'd5; en_n = 1'b0;
    fire(1'b0); measure(n);
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
    n = 0;
    for (int k = 0; k < 6; k++) begin
      #1 if (!seq_done) n++;
      @(negedge clk);
    end
    chk_eq("R7 non-crystal wake drops", n, 0);

    // R8: pin held low through the chain
    mode = 3'd4; en_n = 1'b0; ext_n = 1'b0;
    fire(1'b0);
    measure(n);
    chk_eq("R8 chain runs with pin low", n, P + 1);
    chk_eq("R8 core held by pin", int'(core_rst), 1);
    @(negedge clk); ext_n = 1'b1; #1;
    chk_eq("R8 core released at once", int'(core_rst), 0);

    // R4: external-clock mode, timer off: no time-out
    mode = 3'd3; en_n = 1'b1;
    fire(1'b0);
    measure(n);
    chk_eq("R4 no time-out", n, 1);
    chk_eq("R1 core released", int'(core_rst), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule